// File: doc/BRIEF.md
# Parallel-port enhanced-mode read sequencer

This block is the host-side engine that serves a host-bus read of an enhanced-mode parallel-port data or address register. When the host raises its read strobe, the block stalls the host through a ready line. It waits for the peripheral's wait line to show it is free, then turns the parallel data bus around to input and asserts a data strobe or an address strobe. When the peripheral raises its wait line to mark valid data, the block captures the byte, removes the strobe and presents the byte to the host with ready released. The bus direction and the write line are held in the read configuration until the peripheral lowers its wait line again.

When no read is in progress, the bus direction, the bus output enable and the shared control outputs follow plain control-port settings supplied from outside. The peripheral's wait input passes through a two-stage synchronizer before any decision uses it. A watchdog counts clock cycles while the host read strobe is high. If the access is still stalled after a time limit derived from the clock frequency, the cycle is abandoned: strobes drop, ready is released, all-ones is returned and a sticky timeout flag is set.

Top module: `epp_read_ctrl`

## Requirements
- R1: After reset, host_rdy is 1, timeout_flag is 0, host_rdata is 0, both peripheral strobes are high (inactive) and the pins follow the control-port inputs.
- R2: While no read is in progress, raising host_rd drives host_rdy to 0 in the same cycle, with no clock edge in between. host_rdy stays 0 until the byte is presented or the cycle is aborted.
- R3: No strobe is asserted while the synchronized wait line is high, and the pins keep their control-port values during that time. After p_wait_n falls, the strobe goes low on the fourth rising edge.
- R4: For at least one cycle before a strobe goes low, and for as long as it stays low, p_data_oe is 0, p_dir is 1 and p_write_n is 1.
- R5: host_addr_sel = 0 selects the data strobe p_dstb_n and host_addr_sel = 1 selects the address strobe p_astb_n. The value is sampled when the read starts, and the two strobes are never low together.
- R6: Once a strobe is low, a rise of p_wait_n is acted on at the third rising edge. At that edge p_data_in is captured, the strobe returns high, host_rdata shows the captured byte and host_rdy goes to 1. Later changes of p_data_in do not alter host_rdata.
- R7: After a byte is captured, p_dir, p_data_oe and p_write_n stay in the read configuration until the synchronized wait line is low. They return to the control-port values on the third rising edge after p_wait_n falls.
- R8: The watchdog limit is TIMEOUT_NS of CLK_HZ clock cycles, rounded down. If host_rd has been high for that many rising edges and the read is still stalled, the next edge aborts it: strobes go high, host_rdy goes to 1, host_rdata becomes all ones and timeout_flag goes to 1.
- R9: timeout_flag stays 1 until a cycle with stat_clr = 1 or a reset clears it.
- R10: With no read in progress: p_dir = spp_dir, p_data_oe = not spp_dir, p_write_n = not spp_strobe, p_dstb_n = not spp_autofd and p_init_n = not spp_init. p_astb_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rd | input | 1 | Host read strobe for an enhanced-mode register, active high |
| host_addr_sel | input | 1 | 0 = data register, 1 = address register |
| host_rdy | output | 1 | Host ready; 0 stalls the host bus |
| host_rdata | output | DW | Byte returned to the host |
| stat_clr | input | 1 | Clears the timeout flag |
| timeout_flag | output | 1 | Sticky watchdog timeout status |
| spp_dir | input | 1 | Control-port direction bit, 1 = input |
| spp_strobe | input | 1 | Control-port strobe bit |
| spp_autofd | input | 1 | Control-port auto-feed bit |
| spp_init | input | 1 | Control-port init bit |
| p_wait_n | input | 1 | Peripheral wait line |
| p_data_in | input | DW | Parallel data bus as received |
| p_data_oe | output | 1 | Output enable of the parallel data drivers |
| p_dir | output | 1 | Bus direction control, 1 = input |
| p_write_n | output | 1 | Write line, shared with the strobe pin |
| p_dstb_n | output | 1 | Data strobe, shared with the auto-feed pin |
| p_astb_n | output | 1 | Address strobe |
| p_init_n | output | 1 | Init pin |

## Verification
The hardest situation to reach from the ports is a watchdog abort while a strobe is already low. It needs the peripheral to accept the strobe but never answer. The bench holds p_wait_n low through the turnaround so that the strobe asserts, then leaves it low and counts edges up to the computed limit. It checks that the strobe is still asserted one edge before the limit is reached and released at the limit edge. A second case keeps the peripheral busy before the strobe, so the abort also happens without any strobe ever being asserted.

// File: rtl/epp_rd_pkg.sv
package epp_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TAIL,
        ST_RECOVER,
        ST_ABORT
    } rd_state_e;
endpackage

// File: rtl/epp_rd_sync2.sv
module epp_rd_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q, meta_d;
    logic sync_q, sync_d;

    always_comb begin
        meta_d = din;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RESET_VAL;
            sync_q <= RESET_VAL;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/epp_rd_wdog.sv
module epp_rd_wdog #(
    parameter int LIMIT = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!run)
            cnt_d = '0;
        else if (cnt_q == LIM)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == LIM);
endmodule

// File: rtl/epp_rd_fsm.sv
module epp_rd_fsm
    import epp_rd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_rd,
    input  logic          host_addr_sel,
    input  logic          stat_clr,
    input  logic          wait_s,
    input  logic          wdog_exp,
    input  logic [DW-1:0] pdata,
    output rd_state_e     state,
    output logic          sel,
    output logic [DW-1:0] data,
    output logic          tmo
);
    typedef struct packed {
        rd_state_e     state;
        logic          sel;
        logic [DW-1:0] data;
        logic          tmo;
    } rd_regs_t;

    rd_regs_t r_q, r_d;
    logic     stalled;
    logic     tmo_set;

    always_comb begin
        r_d     = r_q;
        tmo_set = 1'b0;
        stalled = (r_q.state == ST_ARM) || (r_q.state == ST_SETUP) ||
                  (r_q.state == ST_STROBE) || (r_q.state == ST_RECOVER);

        unique case (r_q.state)
            ST_IDLE: begin
                if (host_rd) begin
                    r_d.state = ST_ARM;
                    r_d.sel   = host_addr_sel;
                end
            end
            ST_ARM:    if (!wait_s) r_d.state = ST_SETUP;
            ST_SETUP:  if (!wait_s) r_d.state = ST_STROBE;
            ST_STROBE: begin
                if (wait_s) begin
                    r_d.data  = pdata;
                    r_d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!wait_s)
                    r_d.state = host_rd ? ST_TAIL : ST_IDLE;
                else if (!host_rd)
                    r_d.state = ST_RECOVER;
            end
            ST_TAIL:    if (!host_rd) r_d.state = ST_IDLE;
            ST_RECOVER: if (!wait_s)  r_d.state = ST_IDLE;
            ST_ABORT:   if (!host_rd) r_d.state = ST_IDLE;
            default:    r_d.state = ST_IDLE;
        endcase

        if (wdog_exp && stalled) begin
            r_d.state = ST_ABORT;
            r_d.data  = '1;
            tmo_set   = 1'b1;
        end

        r_d.tmo = tmo_set | (r_q.tmo & ~stat_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.sel   <= 1'b0;
            r_q.data  <= '0;
            r_q.tmo   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.state;
    assign sel   = r_q.sel;
    assign data  = r_q.data;
    assign tmo   = r_q.tmo;
endmodule

// File: rtl/epp_read_ctrl.sv
module epp_read_ctrl
    import epp_rd_pkg::*;
#(
    parameter int CLK_HZ     = 125_000_000,
    parameter int TIMEOUT_NS = 10_000,
    parameter int DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_rd,
    input  logic          host_addr_sel,
    output logic          host_rdy,
    output logic [DW-1:0] host_rdata,
    input  logic          stat_clr,
    output logic          timeout_flag,
    input  logic          spp_dir,
    input  logic          spp_strobe,
    input  logic          spp_autofd,
    input  logic          spp_init,
    input  logic          p_wait_n,
    input  logic [DW-1:0] p_data_in,
    output logic          p_data_oe,
    output logic          p_dir,
    output logic          p_write_n,
    output logic          p_dstb_n,
    output logic          p_astb_n,
    output logic          p_init_n
);
    localparam longint TMO_PROD = longint'(CLK_HZ) * longint'(TIMEOUT_NS);
    localparam int     TMO_CYC  = int'(TMO_PROD / 64'd1_000_000_000);

    logic      wait_s;
    logic      wdog_exp;
    rd_state_e state;
    logic      sel;
    logic      in_read;
    logic      stb_on;
    logic      stall;

    epp_rd_sync2 #(.RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (p_wait_n),
        .dout (wait_s)
    );

    epp_rd_wdog #(.LIMIT(TMO_CYC)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (host_rd),
        .expired(wdog_exp)
    );

    epp_rd_fsm #(.DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_rd      (host_rd),
        .host_addr_sel(host_addr_sel),
        .stat_clr     (stat_clr),
        .wait_s       (wait_s),
        .wdog_exp     (wdog_exp),
        .pdata        (p_data_in),
        .state        (state),
        .sel          (sel),
        .data         (host_rdata),
        .tmo          (timeout_flag)
    );

    always_comb begin
        in_read = (state == ST_SETUP) || (state == ST_STROBE) ||
                  (state == ST_HOLD)  || (state == ST_RECOVER);
        stb_on  = (state == ST_STROBE);
        stall   = (state == ST_IDLE) || (state == ST_ARM) || (state == ST_SETUP) ||
                  (state == ST_STROBE) || (state == ST_RECOVER);

        host_rdy  = ~(host_rd & stall);
        p_dir     = in_read ? 1'b1 : spp_dir;
        p_data_oe = in_read ? 1'b0 : ~spp_dir;
        p_write_n = in_read ? 1'b1 : ~spp_strobe;
        p_dstb_n  = in_read ? ~(stb_on & ~sel) : ~spp_autofd;
        p_astb_n  = ~(stb_on & sel);
        p_init_n  = ~spp_init;
    end
endmodule

// File: rtl/epp_read_ctrl_chk.sv
module epp_read_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_rdy,
    input logic [DW-1:0] host_rdata,
    input logic          stat_clr,
    input logic          timeout_flag,
    input logic          p_data_oe,
    input logic          p_dir,
    input logic          p_write_n,
    input logic          p_dstb_n,
    input logic          p_astb_n,
    input logic          wait_s,
    input logic          stb_on
);
    AST_STB_NEEDS_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_on) |-> !$past(wait_s)); // R3
    AST_BUS_TURNED: assert property (@(posedge clk) disable iff (!rst_n)
        stb_on |-> (!p_data_oe && p_dir && p_write_n)); // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        stb_on |-> (p_dstb_n != p_astb_n)); // R5
    AST_ABORT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> (host_rdy && !stb_on && (host_rdata == '1))); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !stat_clr) |=> timeout_flag); // R9
endmodule

bind epp_read_ctrl epp_read_ctrl_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rdy    (host_rdy),
    .host_rdata  (host_rdata),
    .stat_clr    (stat_clr),
    .timeout_flag(timeout_flag),
    .p_data_oe   (p_data_oe),
    .p_dir       (p_dir),
    .p_write_n   (p_write_n),
    .p_dstb_n    (p_dstb_n),
    .p_astb_n    (p_astb_n),
    .wait_s      (wait_s),
    .stb_on      (stb_on)
);

// File: tb/epp_read_ctrl_test.sv
`timescale 1ns/1ps
module epp_read_ctrl_test;
    localparam int CLK_HZ = 125_000_000;
    localparam int TMO_NS = 10_000;
    localparam int LIMIT  = 1250; // 10 us at 125 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rd = 1'b0, host_addr_sel = 1'b0, stat_clr = 1'b0;
    logic       spp_dir = 1'b0, spp_strobe = 1'b0, spp_autofd = 1'b0, spp_init = 1'b0;
    logic       p_wait_n = 1'b0;
    logic [7:0] p_data_in = 8'h00;
    logic       host_rdy, timeout_flag, p_data_oe, p_dir, p_write_n, p_dstb_n, p_astb_n, p_init_n;
    logic [7:0] host_rdata;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [8:0] VEC [0:5] = '{
        {1'b0, 8'h5A}, {1'b1, 8'hA5}, {1'b0, 8'h00},
        {1'b1, 8'hFF}, {1'b0, 8'h3C}, {1'b1, 8'h81}
    };

    always #4 clk = ~clk;

    epp_read_ctrl #(.CLK_HZ(CLK_HZ), .TIMEOUT_NS(TMO_NS), .DW(8)) uut (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_addr_sel(host_addr_sel),
        .host_rdy(host_rdy), .host_rdata(host_rdata), .stat_clr(stat_clr),
        .timeout_flag(timeout_flag), .spp_dir(spp_dir), .spp_strobe(spp_strobe),
        .spp_autofd(spp_autofd), .spp_init(spp_init), .p_wait_n(p_wait_n),
        .p_data_in(p_data_in), .p_data_oe(p_data_oe), .p_dir(p_dir),
        .p_write_n(p_write_n), .p_dstb_n(p_dstb_n), .p_astb_n(p_astb_n), .p_init_n(p_init_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic [5:0] pins();
        return {p_dir, p_data_oe, p_write_n, p_dstb_n, p_astb_n, p_init_n};
    endfunction

    // idle pin pattern from the control-port inputs (R10)
    function automatic logic [5:0] idle_pins();
        return {spp_dir, ~spp_dir, ~spp_strobe, ~spp_autofd, 1'b1, ~spp_init};
    endfunction

    task automatic do_read(input logic sel, input logic [7:0] val);
        logic [5:0] rdcfg;
        host_addr_sel = sel;
        host_rd = 1'b1;
        #1;
        chk(host_rdy == 1'b0, "R2 stall at once", host_rdy, 0);
        tick(2);
        chk(pins() == {3'b101, 3'b111}, "R4 bus turned before strobe", pins(), {3'b101, 3'b111});
        tick(1);
        rdcfg = {3'b101, sel ? 2'b10 : 2'b01, 1'b1};
        chk(pins() == rdcfg, "R5 strobe select", pins(), rdcfg);
        chk(host_rdy == 1'b0, "R2 stall while strobed", host_rdy, 0);
        p_data_in = val;
        p_wait_n  = 1'b1;
        tick(2);
        chk(pins() == rdcfg, "R6 strobe held during sync", pins(), rdcfg);
        tick(1);
        chk(pins() == {3'b101, 3'b111}, "R6 strobe removed", pins(), {3'b101, 3'b111});
        chk(host_rdy == 1'b1 && host_rdata == val, "R6 data presented", {host_rdy, host_rdata}, {1'b1, val});
        p_data_in = ~val;
        p_wait_n  = 1'b0;
        tick(2);
        chk(host_rdata == val, "R6 capture holds", host_rdata, val);
        chk(pins() == {3'b101, 3'b111}, "R7 read config kept", pins(), {3'b101, 3'b111});
        tick(1);
        chk(pins() == idle_pins(), "R7 released after wait low", pins(), idle_pins());
        host_rd = 1'b0;
        tick(1);
        chk(host_rdy == 1'b1, "R2 ready after end", host_rdy, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #3;
        chk(host_rdy == 1'b1 && timeout_flag == 1'b0, "R1 reset outputs", {host_rdy, timeout_flag}, 2'b10);
        chk(p_dstb_n && p_astb_n && host_rdata == 8'h00, "R1 reset strobes/data", {p_dstb_n, p_astb_n, host_rdata}, {2'b11, 8'h00});
        chk(pins() == idle_pins(), "R1 reset pins", pins(), idle_pins());
        tick(2);
        rst_n = 1'b1;
        tick(2);

        // table-driven reads
        for (int k = 0; k < 6; k++) begin
            do_read(VEC[k][8], VEC[k][7:0]);
            tick(1);
        end

        // control-port pass-through while idle (R10)
        for (int m = 0; m < 16; m++) begin
            {spp_dir, spp_strobe, spp_autofd, spp_init} = 4'(m);
            #1;
            chk(pins() == idle_pins(), "R10 idle follows control port", pins(), idle_pins());
        end
        {spp_dir, spp_strobe, spp_autofd, spp_init} = 4'b0000;
        tick(1);

        // busy peripheral before strobe (R3)
        p_wait_n = 1'b1;
        tick(2);
        host_addr_sel = 1'b0;
        host_rd = 1'b1;
        tick(10);
        chk(pins() == idle_pins() && host_rdy == 1'b0, "R3 no strobe while busy", {pins(), host_rdy}, {idle_pins(), 1'b0});
        p_wait_n = 1'b0;
        tick(3);
        chk(p_dstb_n == 1'b1 && p_write_n == 1'b1, "R3 strobe not before 4th edge", {p_dstb_n, p_write_n}, 2'b11);
        tick(1);
        chk(p_dstb_n == 1'b0, "R3 strobe at 4th edge", p_dstb_n, 0);
        p_data_in = 8'h96;
        p_wait_n  = 1'b1;
        tick(3);
        chk(host_rdata == 8'h96 && host_rdy, "R6 data after busy start", host_rdata, 8'h96);
        // host leaves before peripheral releases
        host_rd = 1'b0;
        tick(3);
        chk(pins() == {3'b101, 3'b111}, "R7 config kept while wait high", pins(), {3'b101, 3'b111});
        p_wait_n = 1'b0;
        tick(3);
        chk(pins() == idle_pins(), "R7 idle after recovery", pins(), idle_pins());

        // timeout before any strobe (R8)
        p_wait_n = 1'b1;
        tick(2);
        host_rd = 1'b1;
        tick(LIMIT);
        chk(host_rdy == 1'b0 && timeout_flag == 1'b0, "R8 no abort at limit", {host_rdy, timeout_flag}, 2'b00);
        tick(1);
        chk(host_rdy && timeout_flag && host_rdata == 8'hFF, "R8 abort", {host_rdy, timeout_flag, host_rdata}, {2'b11, 8'hFF});
        host_rd = 1'b0;
        tick(5);
        chk(timeout_flag == 1'b1, "R9 flag sticky", timeout_flag, 1);
        stat_clr = 1'b1;
        tick(1);
        stat_clr = 1'b0;
        chk(timeout_flag == 1'b0, "R9 cleared by write", timeout_flag, 0);

        // timeout with strobe asserted (R8)
        p_wait_n = 1'b0;
        tick(2);
        host_addr_sel = 1'b1;
        host_rd = 1'b1;
        tick(3);
        chk(p_astb_n == 1'b0, "R5 address strobe", p_astb_n, 0);
        tick(LIMIT - 3);
        chk(p_astb_n == 1'b0 && host_rdy == 1'b0, "R8 strobe held before limit", {p_astb_n, host_rdy}, 2'b00);
        tick(1);
        chk(p_astb_n && p_dstb_n && host_rdy && host_rdata == 8'hFF, "R8 strobe abort",
            {p_astb_n, p_dstb_n, host_rdy, host_rdata}, {3'b111, 8'hFF});
        chk(timeout_flag == 1'b1, "R8 flag set", timeout_flag, 1);
        host_rd = 1'b0;
        tick(2);
        rst_n = 1'b0;
        #1;
        chk(timeout_flag == 1'b0, "R9 cleared by reset", timeout_flag, 0);
        tick(1);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule